// File: doc/BRIEF.md
# Register ALU with Stored Carry

This block is the execution datapath of a small 32-bit microcontroller core. Each cycle it takes a first operand, a second operand and an opcode. It returns a 32-bit result combinationally. The second operand comes either from the second source register or from a zero-extended 8-bit immediate.

A single carry flag is kept inside the block. The add and subtract families consume it and update it. Every other operation leaves it alone. The flag lives in a two-state register named `CY_CLEAR` and `CY_SET`, and it resets to `CY_CLEAR`. There are four transitions: clear-to-clear, clear-to-set, set-to-clear and set-to-set. A transition may leave its state only when `op_valid` is high with an arithmetic opcode. The next state is then `CY_SET` if the carry or borrow of that operation is 1, and `CY_CLEAR` otherwise. In every other cycle the state holds.

Register file, decode and memory access sit outside the block.

Top module: `rca_alu`

## Requirements
- R1: When `imm_sel` is 1 the second operand is `imm` zero-extended to 32 bits; when 0 it is `src2`.
- R2: ADD (code 0) returns src1+op2. ADC (code 1) returns src1+op2+carry. When `op_valid` is high, the carry flag on the next clock becomes bit 32 of that full-precision sum.
- R3: SUB (code 2) returns src1-op2. SUC (code 3) returns src1-op2-carry. When `op_valid` is high, the next carry becomes bit 32 of the full-precision difference, which is 1 exactly on a borrow.
- R4: RSB (code 4) returns op2-src1. RSC (code 5) returns op2-src1-carry. The carry update follows the same rule as R3.
- R5: LSL (code 6) and LSR (code 7) shift src1 left or right by the low 5 bits of op2, filling with zeros.
- R6: AND (code 8), OR (code 9) and XOR (code 10) combine src1 and op2 bitwise. NOT (code 11) returns the complement of src1 and ignores op2.
- R7: MIN (code 12) and MAX (code 13) return the smaller or the larger operand, compared as unsigned numbers.
- R8: CLR (code 14) and SET (code 15) clear or set, in src1, the bit whose index is the low 5 bits of op2.
- R9: SCAN (code 16) returns the highest index i, searching from 31 down to 0, where src1 bit i equals op2 bit 0. If no bit matches it returns 32.
- R10: The carry flag changes only on a clock where `op_valid` is high with an opcode from 0 to 5. Other opcodes, and cycles where `op_valid` is low, leave it unchanged.
- R11: While `rst_n` is low the carry flag is 0.
- R12: Opcodes 17 to 31 return a result of 0 and leave the carry flag unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | Operation issued this cycle; enables the carry update |
| op_code | input | 5 | Operation select |
| imm_sel | input | 1 | Take the immediate as second operand |
| src1 | input | 32 | First operand |
| src2 | input | 32 | Second source register value |
| imm | input | 8 | Immediate operand |
| result | output | 32 | Combinational result |
| carry_flag | output | 1 | Stored carry flag |

## Verification
The bench builds the block with its default widths: a 32-bit datapath and an 8-bit immediate. With these widths the carry sits at bit 32, and a shift count or bit index of 32 or more wraps through the 5-bit field. Operands with the top bit set show whether MIN and MAX compare as unsigned. A scan with no matching bit must return 32, one past the highest index. Directed corners chain ADC, SUC and RSC through a carry set by the operation before. A long stream of pseudo-random operations then mixes idle cycles, unused opcodes and immediates, and compares result and flag against the behavioural model on every clock.

// File: rtl/alu_pkg.sv
package alu_pkg;
    localparam int OPC_W = 5;

    typedef enum logic [OPC_W-1:0] {
        OP_ADD  = 5'd0,
        OP_ADC  = 5'd1,
        OP_SUB  = 5'd2,
        OP_SUC  = 5'd3,
        OP_RSB  = 5'd4,
        OP_RSC  = 5'd5,
        OP_LSL  = 5'd6,
        OP_LSR  = 5'd7,
        OP_AND  = 5'd8,
        OP_OR   = 5'd9,
        OP_XOR  = 5'd10,
        OP_NOT  = 5'd11,
        OP_MIN  = 5'd12,
        OP_MAX  = 5'd13,
        OP_CLR  = 5'd14,
        OP_SET  = 5'd15,
        OP_SCAN = 5'd16
    } alu_op_e;

    typedef enum logic {
        CY_CLEAR = 1'b0,
        CY_SET   = 1'b1
    } cy_state_e;

    function automatic logic is_arith(input logic [OPC_W-1:0] code);
        return code <= OP_RSC;
    endfunction
endpackage

// File: rtl/alu_arith.sv
module alu_arith
    import alu_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [OPC_W-1:0] op,
    input  logic [W-1:0]     a,
    input  logic [W-1:0]     b,
    input  logic             cin,
    output logic [W-1:0]     res,
    output logic             cout
);
    logic [W:0] ext_a;
    logic [W:0] ext_b;
    logic [W:0] ext_c;
    logic [W:0] full;

    assign ext_a = {1'b0, a};
    assign ext_b = {1'b0, b};
    assign ext_c = {{W{1'b0}}, cin};

    always_comb begin
        case (op)
            OP_ADD:  full = ext_a + ext_b;
            OP_ADC:  full = ext_a + ext_b + ext_c;
            OP_SUB:  full = ext_a - ext_b;
            OP_SUC:  full = ext_a - ext_b - ext_c;
            OP_RSB:  full = ext_b - ext_a;
            OP_RSC:  full = ext_b - ext_a - ext_c;
            default: full = '0;
        endcase
    end

    assign res  = full[W-1:0];
    assign cout = full[W];
endmodule

// File: rtl/alu_bitops.sv
module alu_bitops
    import alu_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [OPC_W-1:0] op,
    input  logic [W-1:0]     a,
    input  logic [W-1:0]     b,
    output logic [W-1:0]     res
);
    localparam int SH_W = $clog2(W);

    logic [SH_W-1:0] amt;
    logic [W-1:0]    onehot;

    assign amt    = b[SH_W-1:0];
    assign onehot = {{(W-1){1'b0}}, 1'b1} << amt;

    always_comb begin
        case (op)
            OP_LSL:  res = a << amt;
            OP_LSR:  res = a >> amt;
            OP_AND:  res = a & b;
            OP_OR:   res = a | b;
            OP_XOR:  res = a ^ b;
            OP_NOT:  res = ~a;
            OP_MIN:  res = (a < b) ? a : b;
            OP_MAX:  res = (a > b) ? a : b;
            OP_CLR:  res = a & ~onehot;
            OP_SET:  res = a | onehot;
            default: res = '0;
        endcase
    end
endmodule

// File: rtl/alu_scan.sv
module alu_scan #(
    parameter int W    = 32,
    parameter int IX_W = $clog2(W + 1)
) (
    input  logic [W-1:0]    a,
    input  logic            want,
    output logic [IX_W-1:0] idx
);
    always_comb begin
        idx = IX_W'(W);
        for (int i = 0; i < W; i++) begin
            if (a[i] == want) idx = IX_W'(i);
        end
    end
endmodule

// File: rtl/rca_alu.sv
module rca_alu
    import alu_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int IMM_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              op_valid,
    input  logic [4:0]        op_code,
    input  logic              imm_sel,
    input  logic [DATA_W-1:0] src1,
    input  logic [DATA_W-1:0] src2,
    input  logic [IMM_W-1:0]  imm,
    output logic [DATA_W-1:0] result,
    output logic              carry_flag
);
    localparam int IX_W = $clog2(DATA_W + 1);

    logic [DATA_W-1:0] op2;
    logic [DATA_W-1:0] arith_res;
    logic [DATA_W-1:0] bit_res;
    logic [IX_W-1:0]   scan_idx;
    logic              arith_cout;
    cy_state_e         cy_q;
    cy_state_e         cy_d;

    assign op2 = imm_sel ? {{(DATA_W-IMM_W){1'b0}}, imm} : src2;

    alu_arith #(.W(DATA_W)) u_arith (
        .op(op_code), .a(src1), .b(op2), .cin(carry_flag),
        .res(arith_res), .cout(arith_cout)
    );

    alu_bitops #(.W(DATA_W)) u_bitops (
        .op(op_code), .a(src1), .b(op2), .res(bit_res)
    );

    alu_scan #(.W(DATA_W), .IX_W(IX_W)) u_scan (
        .a(src1), .want(op2[0]), .idx(scan_idx)
    );

    always_comb begin
        if (is_arith(op_code))
            result = arith_res;
        else if (op_code == OP_SCAN)
            result = {{(DATA_W-IX_W){1'b0}}, scan_idx};
        else
            result = bit_res;
    end

    // next-state logic of the carry state machine
    always_comb begin
        cy_d = cy_q;
        unique case (cy_q)
            CY_CLEAR: if (op_valid && is_arith(op_code) && arith_cout) cy_d = CY_SET;
            CY_SET:   if (op_valid && is_arith(op_code) && !arith_cout) cy_d = CY_CLEAR;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cy_q <= CY_CLEAR;
        else        cy_q <= cy_d;
    end

    // output decode
    always_comb begin
        unique case (cy_q)
            CY_CLEAR: carry_flag = 1'b0;
            CY_SET:   carry_flag = 1'b1;
        endcase
    end
endmodule

// File: rtl/alu_chk.sv
module alu_chk #(
    parameter int DATA_W = 32,
    parameter int IMM_W  = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              op_valid,
    input logic [4:0]        op_code,
    input logic              imm_sel,
    input logic [DATA_W-1:0] src1,
    input logic [DATA_W-1:0] src2,
    input logic [IMM_W-1:0]  imm,
    input logic [DATA_W-1:0] result,
    input logic              carry_flag
);
    logic [DATA_W-1:0] c_op2;
    logic [DATA_W:0]   c_sum;

    assign c_op2 = imm_sel ? DATA_W'(imm) : src2;
    assign c_sum = {1'b0, src1} + {1'b0, c_op2};

    assert_carry_reset_R11: assert property (@(posedge clk)
        !rst_n |=> !carry_flag);

    assert_carry_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!op_valid || op_code > 5'd5) |=> $stable(carry_flag));

    assert_add_carry_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_code == 5'd0) |=> carry_flag == $past(c_sum[DATA_W]));

    assert_sub_borrow_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_code == 5'd2) |=> carry_flag == $past(src1 < c_op2));

    assert_min_sel_R7: assert property (@(posedge clk) disable iff (!rst_n)
        op_code == 5'd12 |-> (result <= src1 && result <= c_op2
                              && (result == src1 || result == c_op2)));

    assert_scan_range_R9: assert property (@(posedge clk) disable iff (!rst_n)
        op_code == 5'd16 |-> result <= DATA_W);

    assert_not_compl_R6: assert property (@(posedge clk) disable iff (!rst_n)
        op_code == 5'd11 |-> (result ^ src1) == {DATA_W{1'b1}});

    assert_imm_zext_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (op_code == 5'd8 && imm_sel) |-> result[DATA_W-1:IMM_W] == '0);
endmodule

bind rca_alu alu_chk #(.DATA_W(DATA_W), .IMM_W(IMM_W)) u_chk (.*);

// File: tb/test_rca_alu.sv
`timescale 1ns/1ps
module test_rca_alu;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_valid = 1'b0;
    logic [4:0]  op_code = '0;
    logic        imm_sel = 1'b0;
    logic [31:0] src1 = '0;
    logic [31:0] src2 = '0;
    logic [7:0]  imm = '0;
    logic [31:0] result;
    logic        carry_flag;

    int tests = 0;
    int fails = 0;
    bit model_cy = 1'b0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    rca_alu i_rca_alu (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
        .imm_sel(imm_sel), .src1(src1), .src2(src2), .imm(imm),
        .result(result), .carry_flag(carry_flag)
    );

    function automatic string req_of(input int code);
        if (code <= 1) return "R2";
        if (code <= 3) return "R3";
        if (code <= 5) return "R4";
        if (code <= 7) return "R5";
        if (code <= 11) return "R6";
        if (code <= 13) return "R7";
        if (code <= 15) return "R8";
        if (code == 16) return "R9";
        return "R12";
    endfunction

    // behavioural reference: returns result, sets new carry into ncy
    function automatic logic [31:0] model(input int code, input logic [31:0] a,
                                          input logic [31:0] b, input bit cy,
                                          output bit ncy);
        longint d;
        int sh;
        ncy = cy;
        sh = int'(b % 32);
        case (code)
            0:  d = longint'(a) + longint'(b);
            1:  d = longint'(a) + longint'(b) + longint'(cy);
            2:  d = longint'(a) - longint'(b);
            3:  d = longint'(a) - longint'(b) - longint'(cy);
            4:  d = longint'(b) - longint'(a);
            5:  d = longint'(b) - longint'(a) - longint'(cy);
            default: d = 0;
        endcase
        if (code <= 5) begin
            ncy = ((d >> 32) & 1) != 0;
            return d[31:0];
        end
        case (code)
            6:  return a << sh;
            7:  return a >> sh;
            8:  return a & b;
            9:  return a | b;
            10: return a ^ b;
            11: return ~a;
            12: return (a < b) ? a : b;
            13: return (a > b) ? a : b;
            14: return a & ~(32'd1 << sh);
            15: return a | (32'd1 << sh);
            16: begin
                for (int i = 31; i >= 0; i--)
                    if (a[i] == b[0]) return 32'(i);
                return 32'd32;
            end
            default: return 32'd0;
        endcase
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic run_op(input bit v, input int code, input logic [31:0] a,
                          input logic [31:0] b, input logic [7:0] im, input bit sel);
        logic [31:0] exp;
        logic [31:0] op2;
        bit ncy;
        @(negedge clk);
        op_valid = v; op_code = 5'(code); src1 = a; src2 = b; imm = im; imm_sel = sel;
        op2 = sel ? {24'd0, im} : b;
        exp = model(code, a, op2, model_cy, ncy);
        #1;
        chk(sel ? {req_of(code), "/R1"} : req_of(code), result, exp);
        @(posedge clk);
        if (v) model_cy = ncy;
        #1;
        chk((v && code <= 5) ? req_of(code) : "R10", {31'd0, carry_flag}, {31'd0, model_cy});
    endtask

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            fails++; tests++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 chk("R11", {31'd0, carry_flag}, 32'd0);
        @(negedge clk) rst_n = 1'b1;

        // R2 add overflow, then ADC consumes the carry
        run_op(1, 0, 32'hFFFF_FFFF, 32'd1, 8'd0, 0);
        run_op(1, 1, 32'd5, 32'd6, 8'd0, 0);
        // R3 borrow, equal operands, SUC with borrow in
        run_op(1, 2, 32'd3, 32'd4, 8'd0, 0);
        run_op(1, 3, 32'd0, 32'd0, 8'd0, 0);
        run_op(1, 2, 32'd7, 32'd7, 8'd0, 0);
        // R4 reverse forms
        run_op(1, 4, 32'd10, 32'd3, 8'd0, 0);
        run_op(1, 5, 32'd1, 32'd9, 8'd0, 0);
        // R1 immediate path
        run_op(1, 0, 32'h100, 32'hDEAD_BEEF, 8'hFF, 1);
        run_op(1, 8, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 8'h5A, 1);
        // R5 shifts wrap at 32
        run_op(1, 6, 32'h8000_0001, 32'd33, 8'd0, 0);
        run_op(1, 7, 32'h8000_0001, 32'd31, 8'd0, 0);
        // R6
        run_op(1, 11, 32'h1234_5678, 32'hFFFF_0000, 8'd0, 0);
        run_op(1, 10, 32'hF0F0_F0F0, 32'h0FF0_0FF0, 8'd0, 0);
        // R7 unsigned compare
        run_op(1, 12, 32'h8000_0000, 32'd1, 8'd0, 0);
        run_op(1, 13, 32'h8000_0000, 32'd1, 8'd0, 0);
        // R8 index wraps
        run_op(1, 14, 32'hFFFF_FFFF, 32'd37, 8'd0, 0);
        run_op(1, 15, 32'd0, 32'd63, 8'd0, 0);
        // R9 scans
        run_op(1, 16, 32'h0001_0000, 32'd1, 8'd0, 0);
        run_op(1, 16, 32'hFFFF_FFFF, 32'd0, 8'd0, 0);
        run_op(1, 16, 32'hFFFF_FFFE, 32'd0, 8'd0, 0);
        // R10 set carry then try to disturb it
        run_op(1, 2, 32'd0, 32'd1, 8'd0, 0);
        run_op(0, 0, 32'd1, 32'd1, 8'd0, 0);
        run_op(1, 9, 32'd0, 32'd0, 8'd0, 0);
        // R12 unused opcode
        run_op(1, 20, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 8'd0, 0);
        run_op(1, 31, 32'h1, 32'h1, 8'd0, 0);

        for (int n = 0; n < 400; n++) begin
            run_op(($urandom % 5) != 0, int'($urandom % 20), $urandom,
                   (n % 3 == 0) ? 32'($urandom % 40) : $urandom,
                   8'($urandom), ($urandom % 4) == 0);
        end

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule